// File: doc/BRIEF.md
# Quadword Load Register-Pair Steering Unit

This unit carries out a 16-byte integer load into an aligned pair of general-purpose registers. On a start pulse it forms the effective address from a base register value and a signed displacement field. The displacement is scaled by sixteen. The unit then reads the two doublewords of the quadword through a simple request/response memory port, always the lower address first. It keeps both responses and, when the second one has arrived, writes the pair through two register-write ports in a single cycle.

The endianness mode is captured at start. In big-endian mode the doublewords go across unchanged: the lower address goes to the even register. In little-endian mode the mapping is crossed and every byte is reversed. A start with an odd target register number is refused: the unit raises an invalid-form pulse, reads nothing and writes nothing.

Top module: `qpair_load`

## Requirements
- R1: The first read address is B + sign_extend({dq, 4'b0000}). B is `base_val`, or zero when `base_idx` is 0. `dq` is the displacement field, and the sum wraps modulo 2^XLEN.
- R2: Exactly two reads are issued per accepted operation, the first at EA and the second at EA+8. A request holds its address steady until `mem_rvalid` is sampled high.
- R3: In big-endian mode (`le_mode`=0 at start), the even register receives the doubleword read at EA and the odd register receives the one at EA+8.
- R4: In little-endian mode (`le_mode`=1 at start), the even register receives the byte-reversed doubleword at EA+8 and the odd register receives the byte-reversed doubleword at EA. Byte reversal swaps bits [8k+7:8k] with bits [63-8k:56-8k].
- R5: Both write strobes rise together for exactly one cycle, in the cycle after the second response. The even index is `tgt_idx` and the odd index is `tgt_idx` with bit 0 set.
- R6: A start with `tgt_idx[0]`=1 raises `invalid_form` for exactly one cycle, in the cycle after start, with no memory request and no register write.
- R7: A start pulse while `busy` is high is ignored: no invalid-form pulse, and the running operation completes with its own captured operands.
- R8: After reset, `mem_req`, both write strobes, `invalid_form` and `busy` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| base_idx | input | RA_W | Base register number; 0 selects a zero base |
| base_val | input | XLEN | Contents of the base register |
| dq | input | DQ_W | Signed displacement field, in units of 16 bytes |
| tgt_idx | input | RA_W | Target register number (must be even) |
| le_mode | input | 1 | 1 = little-endian mode |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Read request valid |
| mem_addr | output | XLEN | Read doubleword address |
| mem_rvalid | input | 1 | Read response valid, completes the current request |
| mem_rdata | input | XLEN | Read response data |
| wr_even_en | output | 1 | Even register write strobe |
| wr_even_idx | output | RA_W | Even register number |
| wr_even_data | output | XLEN | Even register write data |
| wr_odd_en | output | 1 | Odd register write strobe |
| wr_odd_idx | output | RA_W | Odd register number |
| wr_odd_data | output | XLEN | Odd register write data |
| invalid_form | output | 1 | One-cycle pulse for an odd target number |

## Verification
The assertions take for granted that the memory raises `mem_rvalid` only while `mem_req` is high and gives one response per request. They also assume that `base_idx`, `base_val`, `dq`, `tgt_idx` and `le_mode` are meaningful only in the start cycle. The stimulus follows this rule. The memory model answers only an open request, after a random delay of zero to two cycles, and drops `mem_rvalid` in the next cycle. Operands are random, and the directed cases cover a zero base register, negative and extreme displacements, address wrap, odd targets and a start while busy.

// File: rtl/qpl_pkg.sv
package qpl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD0  = 2'd1,
        ST_RD1  = 2'd2,
        ST_WB   = 2'd3
    } qpl_state_e;
endpackage

// File: rtl/qpl_ea_gen.sv
module qpl_ea_gen #(
    parameter int XLEN = 64,
    parameter int RA_W = 5,
    parameter int DQ_W = 12
) (
    input  logic [RA_W-1:0] base_idx,
    input  logic [XLEN-1:0] base_val,
    input  logic [DQ_W-1:0] dq,
    output logic [XLEN-1:0] ea
);
    localparam int EXT_W = XLEN - DQ_W - 4;

    logic [XLEN-1:0] base_eff;
    logic [XLEN-1:0] offset;

    always_comb begin
        base_eff = (base_idx == '0) ? '0 : base_val;
        offset   = {{EXT_W{dq[DQ_W-1]}}, dq, 4'b0000};
        ea       = base_eff + offset;
    end
endmodule

// File: rtl/qpl_byte_rev.sv
module qpl_byte_rev #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] din,
    output logic [XLEN-1:0] dout
);
    localparam int NBYTES = XLEN / 8;

    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        assign dout[8*k +: 8] = din[8*(NBYTES-1-k) +: 8];
    end
endmodule

// File: rtl/qpl_steer.sv
module qpl_steer #(
    parameter int XLEN = 64
) (
    input  logic            le,
    input  logic [XLEN-1:0] dw_lo,
    input  logic [XLEN-1:0] dw_hi,
    output logic [XLEN-1:0] even_data,
    output logic [XLEN-1:0] odd_data
);
    logic [XLEN-1:0] lo_rev;
    logic [XLEN-1:0] hi_rev;

    qpl_byte_rev #(.XLEN(XLEN)) u_rev_lo (.din(dw_lo), .dout(lo_rev));
    qpl_byte_rev #(.XLEN(XLEN)) u_rev_hi (.din(dw_hi), .dout(hi_rev));

    always_comb begin
        if (le) begin
            even_data = hi_rev;
            odd_data  = lo_rev;
        end else begin
            even_data = dw_lo;
            odd_data  = dw_hi;
        end
    end
endmodule

// File: rtl/qpair_load.sv
module qpair_load
    import qpl_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int RA_W = 5,
    parameter int DQ_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [RA_W-1:0] base_idx,
    input  logic [XLEN-1:0] base_val,
    input  logic [DQ_W-1:0] dq,
    input  logic [RA_W-1:0] tgt_idx,
    input  logic            le_mode,
    output logic            busy,
    output logic            mem_req,
    output logic [XLEN-1:0] mem_addr,
    input  logic            mem_rvalid,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            wr_even_en,
    output logic [RA_W-1:0] wr_even_idx,
    output logic [XLEN-1:0] wr_even_data,
    output logic            wr_odd_en,
    output logic [RA_W-1:0] wr_odd_idx,
    output logic [XLEN-1:0] wr_odd_data,
    output logic            invalid_form
);
    localparam int PAIR_W = RA_W - 1;
    localparam logic [XLEN-1:0] DW_STEP = XLEN'(XLEN / 8);

    typedef struct packed {
        qpl_state_e       st;
        logic [XLEN-1:0]  ea;
        logic [XLEN-1:0]  dw_lo;
        logic [XLEN-1:0]  dw_hi;
        logic [PAIR_W-1:0] pair;
        logic             le;
        logic             inv;
    } qpl_regs_t;

    qpl_regs_t state_d, state_q;
    logic [XLEN-1:0] ea_calc;

    qpl_ea_gen #(.XLEN(XLEN), .RA_W(RA_W), .DQ_W(DQ_W)) u_ea (
        .base_idx (base_idx),
        .base_val (base_val),
        .dq       (dq),
        .ea       (ea_calc)
    );

    qpl_steer #(.XLEN(XLEN)) u_steer (
        .le        (state_q.le),
        .dw_lo     (state_q.dw_lo),
        .dw_hi     (state_q.dw_hi),
        .even_data (wr_even_data),
        .odd_data  (wr_odd_data)
    );

    always_comb begin
        state_d     = state_q;
        state_d.inv = 1'b0;
        case (state_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (tgt_idx[0]) begin
                        state_d.inv = 1'b1;
                    end else begin
                        state_d.st   = ST_RD0;
                        state_d.ea   = ea_calc;
                        state_d.pair = tgt_idx[RA_W-1:1];
                        state_d.le   = le_mode;
                    end
                end
            end
            ST_RD0: begin
                if (mem_rvalid) begin
                    state_d.dw_lo = mem_rdata;
                    state_d.st    = ST_RD1;
                end
            end
            ST_RD1: begin
                if (mem_rvalid) begin
                    state_d.dw_hi = mem_rdata;
                    state_d.st    = ST_WB;
                end
            end
            default: state_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        busy         = (state_q.st != ST_IDLE);
        mem_req      = (state_q.st == ST_RD0) || (state_q.st == ST_RD1);
        mem_addr     = (state_q.st == ST_RD1) ? state_q.ea + DW_STEP : state_q.ea;
        wr_even_en   = (state_q.st == ST_WB);
        wr_odd_en    = (state_q.st == ST_WB);
        wr_even_idx  = {state_q.pair, 1'b0};
        wr_odd_idx   = {state_q.pair, 1'b1};
        invalid_form = state_q.inv;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));          // R2
    AST_SECOND_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.st == ST_RD0 && mem_rvalid) |=> (mem_req && mem_addr == $past(mem_addr) + DW_STEP)); // R2
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_even_en |=> (!wr_even_en && !wr_odd_en));                             // R5
    AST_WR_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_even_en) |-> $past(mem_rvalid && mem_req));                     // R5
    AST_INV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_form |-> (!mem_req && !wr_even_en && !wr_odd_en && !busy));      // R6
    AST_INV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_form |=> !invalid_form);                                         // R6
    AST_BUSY_NO_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !invalid_form);                                      // R7
endmodule

// File: tb/qpair_load_tb_top.sv
module qpair_load_tb_top;
    localparam int XLEN = 64;
    localparam int RA_W = 5;
    localparam int DQ_W = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [RA_W-1:0] base_idx = '0;
    logic [XLEN-1:0] base_val = '0;
    logic [DQ_W-1:0] dq = '0;
    logic [RA_W-1:0] tgt_idx = '0;
    logic            le_mode = 1'b0;
    logic            busy;
    logic            mem_req;
    logic [XLEN-1:0] mem_addr;
    logic            mem_rvalid = 1'b0;
    logic [XLEN-1:0] mem_rdata = '0;
    logic            wr_even_en, wr_odd_en, invalid_form;
    logic [RA_W-1:0] wr_even_idx, wr_odd_idx;
    logic [XLEN-1:0] wr_even_data, wr_odd_data;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    qpair_load #(.XLEN(XLEN), .RA_W(RA_W), .DQ_W(DQ_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .base_idx(base_idx),
        .base_val(base_val), .dq(dq), .tgt_idx(tgt_idx), .le_mode(le_mode),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .wr_even_en(wr_even_en), .wr_even_idx(wr_even_idx), .wr_even_data(wr_even_data),
        .wr_odd_en(wr_odd_en), .wr_odd_idx(wr_odd_idx), .wr_odd_data(wr_odd_data),
        .invalid_form(invalid_form)
    );

    function automatic logic [XLEN-1:0] mem_word(input logic [XLEN-1:0] a);
        return {a[31:0] ^ 32'hC3A5_0F1E, ~a[31:0] ^ 32'h1234_8765};
    endfunction

    function automatic logic [XLEN-1:0] brev(input logic [XLEN-1:0] d);
        logic [XLEN-1:0] r;
        for (int k = 0; k < XLEN / 8; k++) r[8*k +: 8] = d[8*(XLEN/8-1-k) +: 8];
        return r;
    endfunction

    function automatic logic [XLEN-1:0] exp_ea(input logic [RA_W-1:0] ri,
                                               input logic [XLEN-1:0] rv,
                                               input logic [DQ_W-1:0] d);
        logic [XLEN-1:0] off;
        off = {{(XLEN-DQ_W-4){d[DQ_W-1]}}, d, 4'b0000};
        return ((ri == 0) ? '0 : rv) + off;
    endfunction

    task automatic check(input bit ok, input string req, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [RA_W-1:0] ri, input logic [XLEN-1:0] rv,
                          input logic [DQ_W-1:0] d, input logic [RA_W-1:0] t,
                          input logic le, input bit poke);
        logic [XLEN-1:0] ea, addr0, addr1, ev, od;
        int reads, wait_cnt;
        bit saw_inv, got_wr;
        ea = exp_ea(ri, rv, d);
        reads = 0; wait_cnt = $urandom_range(0, 2); saw_inv = 0; got_wr = 0;
        addr0 = '0; addr1 = '0;
        @(negedge clk);
        start = 1; base_idx = ri; base_val = rv; dq = d; tgt_idx = t; le_mode = le;
        @(negedge clk);
        start = 0;
        base_val = ~rv; dq = ~d; tgt_idx = 5'd3; le_mode = ~le;
        for (int cyc = 0; cyc < 40 && !got_wr; cyc++) begin
            if (invalid_form) saw_inv = 1;
            if (poke && cyc == 1) start = 1;
            else start = 0;
            if (wr_even_en) begin
                got_wr = 1;
                ev = le ? brev(mem_word(ea + 8)) : mem_word(ea);
                od = le ? brev(mem_word(ea)) : mem_word(ea + 8);
                check(wr_odd_en, "R5 odd strobe with even", {63'd0, wr_odd_en}, 64'd1);
                check(wr_even_idx == t, "R5 even index", XLEN'(wr_even_idx), XLEN'(t));
                check(wr_odd_idx == (t | 5'd1), "R5 odd index", XLEN'(wr_odd_idx), XLEN'(t | 5'd1));
                if (le) begin
                    check(wr_even_data == ev, "R4 even data", wr_even_data, ev);
                    check(wr_odd_data == od, "R4 odd data", wr_odd_data, od);
                end else begin
                    check(wr_even_data == ev, "R3 even data", wr_even_data, ev);
                    check(wr_odd_data == od, "R3 odd data", wr_odd_data, od);
                end
                mem_rvalid = 0;
            end else if (mem_rvalid) begin
                mem_rvalid = 0;
                wait_cnt = $urandom_range(0, 2);
            end else if (mem_req) begin
                if (wait_cnt == 0) begin
                    if (reads == 0) addr0 = mem_addr; else addr1 = mem_addr;
                    reads++;
                    mem_rvalid = 1;
                    mem_rdata = mem_word(mem_addr);
                end else begin
                    wait_cnt--;
                end
            end
            if (!got_wr) @(negedge clk);
        end
        start = 0;
        check(got_wr, "R5 write reached", {63'd0, got_wr}, 64'd1);
        check(reads == 2, "R2 read count", XLEN'(reads), 64'd2);
        check(addr0 == ea, "R1 first address", addr0, ea);
        check(addr1 == ea + 8, "R2 second address", addr1, ea + 8);
        if (poke) check(!saw_inv, "R7 start while busy ignored", {63'd0, saw_inv}, 64'd0);
        @(negedge clk);
        check(!wr_even_en && !wr_odd_en, "R5 single-cycle write", {63'd0, wr_even_en}, 64'd0);
        check(!busy, "R7 back to idle", {63'd0, busy}, 64'd0);
    endtask

    task automatic run_invalid(input logic [RA_W-1:0] t);
        @(negedge clk);
        start = 1; tgt_idx = t; base_idx = 5'd4; base_val = 64'h1000; dq = 12'h001;
        @(negedge clk);
        start = 0;
        check(invalid_form, "R6 invalid pulse", {63'd0, invalid_form}, 64'd1);
        check(!mem_req && !busy, "R6 no request", {63'd0, mem_req}, 64'd0);
        check(!wr_even_en && !wr_odd_en, "R6 no write", {63'd0, wr_even_en}, 64'd0);
        @(negedge clk);
        check(!invalid_form && !mem_req, "R6 pulse ends", {63'd0, invalid_form}, 64'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!mem_req && !wr_even_en && !wr_odd_en && !invalid_form && !busy,
              "R8 reset outputs", {59'd0, mem_req, wr_even_en, wr_odd_en, invalid_form, busy}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        check(!busy && !mem_req, "R8 idle after reset", {63'd0, busy}, 64'd0);
        run_op(5'd0, 64'hFFFF_0000_DEAD_BEEF, 12'h005, 5'd2, 1'b0, 0);
        run_op(5'd0, 64'h1234, 12'h005, 5'd4, 1'b1, 0);
        run_op(5'd7, 64'h0000_0000_0000_1000, 12'hFFF, 5'd30, 1'b0, 0);
        run_op(5'd9, 64'h0000_0000_0000_0020, 12'h800, 5'd0, 1'b1, 0);
        run_op(5'd31, 64'hFFFF_FFFF_FFFF_FFF8, 12'h7FF, 5'd10, 1'b1, 0);
        run_op(5'd1, 64'h0000_0040_0000_0000, 12'h010, 5'd6, 1'b0, 1);
        run_op(5'd3, 64'h0000_0000_ABCD_0000, 12'h020, 5'd8, 1'b1, 1);
        run_invalid(5'd1);
        run_invalid(5'd31);
        for (int i = 0; i < 40; i++) begin
            run_op(5'($urandom), {$urandom, $urandom}, 12'($urandom),
                   {4'($urandom), 1'b0}, 1'($urandom), ($urandom_range(0, 3) == 0));
            if ($urandom_range(0, 4) == 0) run_invalid({4'($urandom), 1'b1});
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule